// File: doc/BRIEF.md
# Scanned Four-Digit Hex Counter Display

This block drives a four-digit seven-segment display whose seven segment lines are wired in common to all digits. Only one digit can be lit at a time. The block lights the digits one after another fast enough that all four appear lit together. A single wide free-running counter does two jobs. Two of its mid-order bits select the digit being scanned, and four 4-bit fields in its upper part give the hex value each digit shows. Because one counter does both, no separate divider is needed to set the scan rate.

With the default sizes (a 38-bit counter, scan select on bits 18:17, digit fields starting at bit 22) and a 50 MHz clock, one full four-digit sweep takes 2^19 cycles. That is about 95 sweeps per second, which is comfortably above the 60 Hz flicker limit. The value shown on the display counts upward slowly enough to be read.

The anode and segment outputs come from flops. They change together on one clock edge, so a digit never shows the segment pattern meant for another digit. Clock generation is handled outside this block.

Top module: `hexscan_top`

## Requirements
- R1: While `rst` is high at a clock edge, the count is cleared to zero. After that edge, `an_n` is 4'b1110 and `seg_n` shows the glyph for 0 (7'h40).
- R2: Outside reset, exactly one bit of `an_n` is low in every cycle.
- R3: The digit index s is taken from count bits [SEL_LSB+1:SEL_LSB], and it drives `an_n[s]` low.
- R4: Digits light in the order 0, 1, 2, 3, 0, and so on. Each digit stays lit for 2^SEL_LSB consecutive cycles, which is one quarter of the sweep.
- R5: When digit d is lit, the nibble it shows is count bits [NIB_LSB+4d+3 : NIB_LSB+4d].
- R6: `seg_n` is active-low with bit 0 = segment a through bit 6 = segment g. The lit-segment patterns, written as active-high hex with bit 0 = a, are: 0:3F, 1:06, 2:5B, 3:4F, 4:66, 5:6D, 6:7D, 7:07, 8:7F, 9:6F, A:77, b:7C, C:39, d:5E, E:79, F:71. All sixteen patterns are distinct.
- R7: The outputs are registered. After each clock edge they reflect the count value held just before that edge, and the anode and segment lines update on the same edge.
- R8: The count rises by one on every clock edge outside reset. After all ones it wraps to zero, and the display returns to the reset image.
- R9: A reset asserted in the middle of a run restores the reset image at the next edge, and the sequence then starts over from count zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Display clock |
| rst | input | 1 | Synchronous reset, active high |
| an_n | output | 4 | Digit anode enables, active low |
| seg_n | output | 7 | Segment lines a..g (bit 0..6), active low |

## Verification
The bench builds the design with a 17-bit counter, the scan select on bits 1:0 and the digit fields from bit 1 up. Under these sizes every digit changes each cycle and the whole count range wraps within the run. Each cycle's anode and segment value is compared against a count model kept in the bench. An off-by-one in the output register stage would show up as every digit showing its neighbour's value or lagging a cycle. A wrong field offset or a reversed scan order would light the right anode with the wrong nibble. A bad glyph entry would appear as a repeated or incorrect pattern once all sixteen values have been seen. The bench also checks the wrap back to the zero image and a reset applied mid-sweep, so a design that fails to restart the count from zero is caught.

// File: rtl/hexscan_pkg.sv
package hexscan_pkg;
  localparam int DIGITS = 4;
  localparam int SEL_W  = $clog2(DIGITS);
  localparam int NIB_W  = 4;
  localparam int SEG_W  = 7;
  localparam int FIELD_W = DIGITS * NIB_W;

  typedef logic [SEG_W-1:0] seg_t;
  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [DIGITS-1:0] an_t;

  // idle images shown while reset is held: digit 0 lit with glyph 0
  localparam an_t  AN_RESET  = 4'b1110;
  localparam seg_t SEG_RESET = 7'h40;
endpackage

// File: rtl/hexscan_counter.sv
module hexscan_counter #(
  parameter int CNT_W = 38
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/hexscan_digit_sel.sv
module hexscan_digit_sel
  import hexscan_pkg::*;
(
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [FIELD_W-1:0] field_i,
  output nib_t               nib_o,
  output an_t                an_n_o
);
  nib_t nibs [DIGITS];

  // slice the value field into one nibble per digit
  for (genvar d = 0; d < DIGITS; d++) begin : g_nib
    assign nibs[d] = field_i[d*NIB_W +: NIB_W];
  end

  always_comb begin
    nib_o  = nibs[sel_i];
    an_n_o = ~(an_t'(1) << sel_i);
  end
endmodule

// File: rtl/hexscan_seg_dec.sv
module hexscan_seg_dec
  import hexscan_pkg::*;
(
  input  nib_t nib_i,
  output seg_t seg_n_o
);
  seg_t lit;

  // active-high pattern, bit0 = a ... bit6 = g
  always_comb begin
    unique case (nib_i)
      4'h0: lit = 7'h3F;
      4'h1: lit = 7'h06;
      4'h2: lit = 7'h5B;
      4'h3: lit = 7'h4F;
      4'h4: lit = 7'h66;
      4'h5: lit = 7'h6D;
      4'h6: lit = 7'h7D;
      4'h7: lit = 7'h07;
      4'h8: lit = 7'h7F;
      4'h9: lit = 7'h6F;
      4'hA: lit = 7'h77;
      4'hB: lit = 7'h7C;
      4'hC: lit = 7'h39;
      4'hD: lit = 7'h5E;
      4'hE: lit = 7'h79;
      default: lit = 7'h71;
    endcase
    seg_n_o = ~lit;
  end
endmodule

// File: rtl/hexscan_top.sv
module hexscan_top
  import hexscan_pkg::*;
#(
  parameter int CNT_W   = 38,
  parameter int SEL_LSB = 17,
  parameter int NIB_LSB = 22
) (
  input  logic       clk,
  input  logic       rst,
  output logic [3:0] an_n,
  output logic [6:0] seg_n
);
  localparam int SEL_MSB = SEL_LSB + SEL_W - 1;
  localparam int NIB_MSB = NIB_LSB + FIELD_W - 1;

  logic [CNT_W-1:0] cnt_w;
  nib_t             nib_w;
  an_t              an_w;
  seg_t             seg_w;
  an_t              an_q;
  seg_t             seg_q;

  hexscan_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .cnt_o(cnt_w)
  );

  hexscan_digit_sel u_sel (
    .sel_i  (cnt_w[SEL_MSB:SEL_LSB]),
    .field_i(cnt_w[NIB_MSB:NIB_LSB]),
    .nib_o  (nib_w),
    .an_n_o (an_w)
  );

  hexscan_seg_dec u_dec (
    .nib_i  (nib_w),
    .seg_n_o(seg_w)
  );

  // one output stage: anode and segments move on the same edge
  always_ff @(posedge clk) begin
    if (rst) begin
      an_q  <= AN_RESET;
      seg_q <= SEG_RESET;
    end else begin
      an_q  <= an_w;
      seg_q <= seg_w;
    end
  end

  assign an_n  = an_q;
  assign seg_n = seg_q;
endmodule

// File: rtl/hexscan_checker.sv
module hexscan_checker #(
  parameter int CNT_W   = 38,
  parameter int SEL_LSB = 17
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       an_n,
  input logic [6:0]       seg_n,
  input logic [CNT_W-1:0] cnt
);
  // R1: image after a reset edge
  assert_reset_image_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (an_n == 4'b1110 && seg_n == 7'h40));

  // R2: one anode at a time
  assert_one_anode_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(~an_n) == 1);

  // R3 and R7: lit anode follows the select bits of the previous count
  assert_anode_follows_select_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> an_n == ~(4'b0001 << $past(cnt[SEL_LSB+1:SEL_LSB])));

  // R4: any change of anode is a one-place rotation upward
  assert_rotation_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(an_n)) |-> an_n == {$past(an_n[2:0]), $past(an_n[3])});

  // R8: counter steps by one each edge
  assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt == $past(cnt) + 1'b1);
endmodule

bind hexscan_top hexscan_checker #(.CNT_W(CNT_W), .SEL_LSB(SEL_LSB)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .an_n (an_n),
  .seg_n(seg_n),
  .cnt  (cnt_w)
);

// File: tb/hexscan_top_tb_top.sv
module hexscan_top_tb_top;
  localparam int TB_W   = 17;
  localparam int TB_SEL = 0;
  localparam int TB_NIB = 1;
  localparam int WDOG   = 180000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] an_n;
  logic [6:0] seg_n;

  int checks = 0;
  int fails  = 0;
  longint n  = 0;
  logic [TB_W-1:0] v = '0;
  logic [6:0] seen_pat [16];
  logic [15:0] seen = '0;

  always #2 clk = ~clk;

  hexscan_top #(.CNT_W(TB_W), .SEL_LSB(TB_SEL), .NIB_LSB(TB_NIB)) dut_i (
    .clk  (clk),
    .rst  (rst),
    .an_n (an_n),
    .seg_n(seg_n)
  );

  function automatic logic [6:0] glyph(input logic [3:0] x);
    case (x)
      4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
      4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
      4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
      4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  function automatic int dsel(input logic [TB_W-1:0] c);
    return int'((c >> TB_SEL) & 2'd3);
  endfunction

  function automatic logic [3:0] exp_nib(input logic [TB_W-1:0] c);
    return 4'((c >> (TB_NIB + 4*dsel(c))) & 4'hF);
  endfunction

  function automatic logic [3:0] exp_an(input logic [TB_W-1:0] c);
    return ~(4'b0001 << dsel(c));
  endfunction

  task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual an/seg=%h expected=%h (model count %0d)", tag, act, exp, v);
    end
  endtask

  // one clock: update model at the edge, sample at the falling edge
  task automatic step();
    @(posedge clk);
    if (rst) begin v = '0; n = 0; end
    else begin v = n[TB_W-1:0]; n = n + 1; end
    @(negedge clk);
  endtask

  task automatic check_full(input string tag);
    check(tag, {an_n, seg_n}, {exp_an(v), ~glyph(exp_nib(v))});
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      check("R1 reset image", {an_n, seg_n}, {4'b1110, 7'h40});
    end
    rst = 1'b0;
  endtask

  task automatic t_scan_order();
    logic [3:0] prev;
    step();
    check_full("R7 first edge after reset");
    prev = an_n;
    for (int i = 0; i < 40; i++) begin
      step();
      check("R2 one anode", {7'd0, 4'($countones(~an_n))}, {7'd0, 4'd1});
      check("R3 anode from select", {7'd0, an_n}, {7'd0, exp_an(v)});
      // TB_SEL = 0: each digit lit exactly one cycle, next one up
      check("R4 rotation", {7'd0, an_n}, {7'd0, prev[2:0], prev[3]});
      prev = an_n;
    end
  endtask

  task automatic t_digit_values();
    int lim = (1 << TB_W) + 8;
    int w0 = 0;
    for (int i = 0; i < lim; i++) begin
      step();
      check_full("R5 R7 digit value");
      if (!seen[exp_nib(v)]) begin
        seen[exp_nib(v)] = 1'b1;
        seen_pat[exp_nib(v)] = seg_n;
      end
      if (v == '0) begin
        check("R8 wrap to zero image", {an_n, seg_n}, {4'b1110, 7'h40});
        w0++;
      end
    end
    check("R8 wrap observed", {10'd0, w0 > 0}, {10'd0, 1'b1});
    check("R6 all glyphs seen", {10'd0, seen == 16'hFFFF}, {10'd0, 1'b1});
    for (int a = 0; a < 16; a++) begin
      check("R6 glyph encoding", {4'd0, seen_pat[a]}, {4'd0, ~glyph(4'(a))});
      for (int b = a + 1; b < 16; b++)
        check("R6 glyphs distinct", {10'd0, seen_pat[a] != seen_pat[b]}, {10'd0, 1'b1});
    end
  endtask

  task automatic t_mid_reset();
    for (int i = 0; i < 37; i++) step();
    rst = 1'b1;
    step();
    check("R9 reset image mid-run", {an_n, seg_n}, {4'b1110, 7'h40});
    rst = 1'b0;
    for (int i = 0; i < 20; i++) begin
      step();
      check_full("R9 restart from zero");
    end
  endtask

  initial begin
    for (int c = 0; c < WDOG; c++) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int a = 0; a < 16; a++) seen_pat[a] = '0;
    @(negedge clk);
    t_reset_state();
    t_scan_order();
    t_digit_values();
    t_mid_reset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule